// File: doc/BRIEF.md
# Cursor and Annunciator Blink Timer

This block produces the blink phase that a display controller uses to flash cursor and annunciator segments. It divides a free-running oscillator tick into two equal phases, "first half" and "second half" of the blink period. A rate-select input chooses a slow period or a fast period. The fast period is half the slow one. A rate change waits for the next phase boundary, so no phase is ever cut short.

Each annunciator in a small group carries a 2-bit mode. The block turns that mode and the current phase into a lit or unlit bit for that annunciator. A restart strobe clears the timer back to the start of the first half, so that several controllers written together blink in step. The same strobe is passed on, one cycle later, as a pulse that restarts the display scan. While the shutdown input is high the timer freezes, and it carries on from the same point when shutdown falls.

Top module: `blink_timer`

## Requirements
- R1: After a synchronous reset, `blink_phase` is 0, `phase_edge` is 0, `scan_restart` is 0 and the slow rate is in force.
- R2: At the slow rate `blink_phase` toggles after exactly SLOW_TICKS clock cycles that have `osc_tick` high. Cycles with `osc_tick` low do not advance the timer.
- R3: At the fast rate `blink_phase` toggles after exactly SLOW_TICKS/2 ticks.
- R4: A change on `rate_fast` is taken only at a phase boundary or at a restart. The phase already in progress keeps the length of the rate that was in force when it began.
- R5: `phase_edge` is high for exactly one cycle, the cycle in which `blink_phase` first shows its new value.
- R6: `ann_mode[2i+1:2i]` controls annunciator i, and `ann_lit[i]` follows it combinationally:
  - 0 is never lit.
  - 1 is lit when `blink_phase` is 0.
  - 2 is lit when `blink_phase` is 1.
  - 3 is always lit.
- R7: While `shutdown` is high, ticks are ignored and both the count and the phase are held. After `shutdown` falls, counting resumes from the held count.
- R8: When `sync_restart` is high in a cycle, the next cycle shows the following:
  - the count is cleared and `blink_phase` is 0;
  - the rate is taken again from `rate_fast`;
  - `phase_edge` stays 0;
  - `scan_restart` is high for one cycle.
  The restart takes priority over a tick and over `shutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick that advances the timer |
| rate_fast | input | 1 | 1 selects the fast blink rate, 0 the slow rate |
| sync_restart | input | 1 | Restart strobe for the blink timer |
| shutdown | input | 1 | Freezes the timer while high |
| ann_mode | input | 2*NUM_ANN | Per-annunciator blink mode, two bits each |
| blink_phase | output | 1 | 0 during the first half of the period, 1 during the second half |
| phase_edge | output | 1 | One-cycle pulse when the phase changes |
| scan_restart | output | 1 | One-cycle pulse telling the display scan to restart |
| ann_lit | output | NUM_ANN | Lit result for each annunciator |

## Verification
The results fall due at different times:
- `blink_phase` and `phase_edge` change in the cycle after the clock edge that takes the last tick of a phase.
- `scan_restart` is due one cycle after the strobe.
- `ann_lit` is combinational, so it is due in the same cycle as a change of mode or phase.

The bench drives every input on the falling clock edge and gives the exact number of ticks for each step. It samples one nanosecond after the next falling edge, so each registered result is read exactly one edge after the stimulus that caused it. The bench checks `phase_edge` again one cycle later to confirm that the pulse lasts a single cycle. The decode table is checked in both phases, with the mode held while the phase is known to be stable.

// File: rtl/blink_pkg.sv
// Package: shared types for the blink timer.
// Assumes: annunciator modes are two-bit codes decoded against the blink phase.
package blink_pkg;

    // Annunciator blink modes
    typedef enum logic [1:0] {
        ANN_OFF    = 2'd0,
        ANN_FIRST  = 2'd1,
        ANN_SECOND = 2'd2,
        ANN_STEADY = 2'd3
    } ann_mode_e;

endpackage

// File: rtl/blink_phase_ctr.sv
// Module: blink_phase_ctr
// Counts oscillator ticks and toggles the blink phase each time the count
// reaches the phase length of the latched rate. The rate is latched only at
// a phase boundary or on a restart. Shutdown freezes the count and the phase.
// Assumes: SLOW_TICKS >= 4 and even; osc_tick is a one-cycle-per-tick enable.
module blink_phase_ctr #(
    parameter int SLOW_TICKS = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic rate_fast,
    input  logic sync_restart,
    input  logic shutdown,
    output logic phase_o,
    output logic edge_o,
    output logic restart_o
);

    localparam int FAST_TICKS = SLOW_TICKS / 2;
    localparam int CNT_W      = $clog2(SLOW_TICKS);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             rate_lat;
    logic [CNT_W-1:0] last;
    logic             advance;
    logic             boundary;

    // Last count value of the phase length in force
    assign last     = rate_lat ? FAST_LAST : SLOW_LAST;
    // A tick counts only outside shutdown and when no restart is pending
    assign advance  = osc_tick && !shutdown && !sync_restart;
    // The tick that completes the current phase
    assign boundary = advance && (cnt == last);

    // Tick counter, phase toggle and rate latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            phase_o  <= 1'b0;
            rate_lat <= 1'b0;
        end else if (sync_restart) begin
            cnt      <= '0;
            phase_o  <= 1'b0;
            rate_lat <= rate_fast;
        end else if (boundary) begin
            cnt      <= '0;
            phase_o  <= ~phase_o;
            rate_lat <= rate_fast;
        end else if (advance) begin
            cnt      <= cnt + 1'b1;
        end
    end

    // One-cycle pulses: phase change and scan restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_o    <= 1'b0;
            restart_o <= 1'b0;
        end else begin
            edge_o    <= boundary;
            restart_o <= sync_restart;
        end
    end

    // R2: the count never passes the last value of the latched rate
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R7: shutdown without restart holds the count and the phase
    p_hold_in_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !sync_restart) |=> ($stable(cnt) && $stable(phase_o)));

    // R8: a restart lands at the start of the first half
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_restart |=> (cnt == '0 && !phase_o && restart_o && !edge_o));

    // R5: the edge pulse coincides with a changed phase
    p_edge_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (phase_o != $past(phase_o)));

    // R4: the latched rate moves only at a boundary or a restart
    p_rate_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !sync_restart) |=> $stable(rate_lat));

endmodule

// File: rtl/blink_ann_decode.sv
// Module: blink_ann_decode
// Turns one annunciator's blink mode and the blink phase into a lit bit.
// Assumes: phase 0 is the first half of the blink period.
module blink_ann_decode
    import blink_pkg::*;
(
    input  ann_mode_e mode,
    input  logic      phase,
    output logic      lit
);

    // Mode-to-lit decode
    always_comb begin
        unique case (mode)
            ANN_OFF:    lit = 1'b0;
            ANN_FIRST:  lit = ~phase;
            ANN_SECOND: lit = phase;
            ANN_STEADY: lit = 1'b1;
            default:    lit = 1'b0;
        endcase
    end

endmodule

// File: rtl/blink_timer.sv
// Module: blink_timer (top)
// Blink phase generator with a per-annunciator lit decode and a restart
// pulse for the display scan.
// Assumes: a synchronous active-low reset; ann_mode packs two bits for each
// annunciator, with annunciator i at bits [2i+1:2i].
module blink_timer
    import blink_pkg::*;
#(
    parameter int SLOW_TICKS = 4_000_000,
    parameter int NUM_ANN    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 osc_tick,
    input  logic                 rate_fast,
    input  logic                 sync_restart,
    input  logic                 shutdown,
    input  logic [2*NUM_ANN-1:0] ann_mode,
    output logic                 blink_phase,
    output logic                 phase_edge,
    output logic                 scan_restart,
    output logic [NUM_ANN-1:0]   ann_lit
);

    // Phase counter shared by all annunciators
    blink_phase_ctr #(
        .SLOW_TICKS (SLOW_TICKS)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_tick     (osc_tick),
        .rate_fast    (rate_fast),
        .sync_restart (sync_restart),
        .shutdown     (shutdown),
        .phase_o      (blink_phase),
        .edge_o       (phase_edge),
        .restart_o    (scan_restart)
    );

    // One decoder per annunciator
    for (genvar g = 0; g < NUM_ANN; g++) begin : g_ann
        blink_ann_decode u_dec (
            .mode  (ann_mode_e'(ann_mode[2*g +: 2])),
            .phase (blink_phase),
            .lit   (ann_lit[g])
        );

        // R6: steady is always lit and off is never lit
        p_mode_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((ann_mode[2*g +: 2] == 2'd3) |-> ann_lit[g]) and
            ((ann_mode[2*g +: 2] == 2'd0) |-> !ann_lit[g]));
    end

endmodule

// File: tb/test_blink_timer.sv
// Bench for blink_timer. A decode vector table is walked in both phases,
// then directed tests cover reset, phase length, rate change, shutdown
// and restart.
module test_blink_timer;

    localparam int SLOW = 8;
    localparam int NA   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          rate_fast = 1'b0;
    logic          sync_restart = 1'b0;
    logic          shutdown = 1'b0;
    logic [2*NA-1:0] ann_mode = '0;
    logic          blink_phase;
    logic          phase_edge;
    logic          scan_restart;
    logic [NA-1:0] ann_lit;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    blink_timer #(.SLOW_TICKS(SLOW), .NUM_ANN(NA)) i_blink_timer (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rate_fast(rate_fast),
        .sync_restart(sync_restart), .shutdown(shutdown), .ann_mode(ann_mode),
        .blink_phase(blink_phase), .phase_edge(phase_edge),
        .scan_restart(scan_restart), .ann_lit(ann_lit)
    );

    // Each vector: {modes, lit in phase 0, lit in phase 1}
    localparam logic [15:0] VEC [6] = '{
        {8'b11_10_01_00, 4'b1010, 4'b1100},
        {8'b00_01_10_11, 4'b0101, 4'b0011},
        {8'hFF,          4'b1111, 4'b1111},
        {8'h00,          4'b0000, 4'b0000},
        {8'h55,          4'b1111, 4'b0000},
        {8'hAA,          4'b0000, 4'b1111}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Give n ticks, one per cycle; returns 1 ns after the following falling edge
    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
        end
        @(negedge clk) osc_tick = 1'b0;
        #1;
    endtask

    // Walk the decode table against a known phase (R6)
    task automatic walk(input bit ph);
        for (int v = 0; v < 6; v++) begin
            ann_mode = VEC[v][15:8];
            #1;
            chk(ph ? "R6 decode phase1" : "R6 decode phase0", int'(ann_lit),
                ph ? int'(VEC[v][3:0]) : int'(VEC[v][7:4]));
        end
    endtask

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 phase", blink_phase, 0);
        chk("R1 edge", phase_edge, 0);
        chk("R1 scan_restart", scan_restart, 0);

        walk(1'b0);

        // R2: no ticks, no advance
        repeat (20) @(negedge clk);
        #1;
        chk("R2 idle phase", blink_phase, 0);

        // R2, R5: slow phase length
        tick_n(SLOW - 1);
        chk("R2 before boundary", blink_phase, 0);
        chk("R5 no early edge", phase_edge, 0);
        tick_n(1);
        chk("R2 toggled", blink_phase, 1);
        chk("R5 edge", phase_edge, 1);
        @(negedge clk);
        #1;
        chk("R5 edge one cycle", phase_edge, 0);

        walk(1'b1);

        // R4: fast selected mid-phase, slow length still applies
        rate_fast = 1'b1;
        tick_n(SLOW - 1);
        chk("R4 deferred", blink_phase, 1);
        tick_n(1);
        chk("R4 boundary", blink_phase, 0);
        // R3: fast phase length
        tick_n(SLOW / 2 - 1);
        chk("R3 before fast boundary", blink_phase, 0);
        tick_n(1);
        chk("R3 fast toggle", blink_phase, 1);

        // R7: shutdown holds, then resumes
        shutdown = 1'b1;
        tick_n(10);
        chk("R7 held phase", blink_phase, 1);
        chk("R7 no edge", phase_edge, 0);
        shutdown = 1'b0;
        tick_n(SLOW / 2 - 1);
        chk("R7 resumed count", blink_phase, 1);
        tick_n(1);
        chk("R7 resumed toggle", blink_phase, 0);

        // R8: restart mid second half, relatch slow
        tick_n(SLOW / 2);
        tick_n(2);
        chk("R8 setup phase", blink_phase, 1);
        rate_fast = 1'b0;
        @(negedge clk) sync_restart = 1'b1;
        @(negedge clk) sync_restart = 1'b0;
        #1;
        chk("R8 phase cleared", blink_phase, 0);
        chk("R8 scan_restart", scan_restart, 1);
        chk("R8 no edge", phase_edge, 0);
        @(negedge clk);
        #1;
        chk("R8 scan_restart one cycle", scan_restart, 0);
        tick_n(SLOW - 1);
        chk("R8 slow relatched", blink_phase, 0);
        tick_n(1);
        chk("R8 slow boundary", blink_phase, 1);

        // R8: restart wins over tick and shutdown
        shutdown = 1'b1;
        tick_n(2);
        @(negedge clk) begin
            sync_restart = 1'b1;
            osc_tick = 1'b1;
        end
        @(negedge clk) begin
            sync_restart = 1'b0;
            osc_tick = 1'b0;
        end
        #1;
        chk("R8 priority", blink_phase, 0);
        shutdown = 1'b0;
        tick_n(SLOW - 1);
        chk("R8 count from zero", blink_phase, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule